// File: doc/BRIEF.md
# Vector Mask Register Access Unit

This unit sits between a vector datapath and a single-port vector register file. It handles the two mask-related accesses that the datapath needs. A mask read fetches one register and turns it into a per-element enable vector. A mask write merges a freshly computed mask into the low bits of a destination register and keeps every bit above the active element count.

A read is controlled by two inputs. The `cmd_vm` input selects between the unmasked case and the mask register's bits. The `cmd_carry` input chooses how the unmasked case is read:
- In ordinary mask mode, the unmasked case enables every active element.
- In carry/borrow mode, the unmasked case supplies a zero carry-in to every element.

In both modes, enable bits at or above the element count are driven to zero.

A write is a two-cycle read-modify-write of the destination register. An element count of zero, or one larger than the register width, is rejected with an error pulse and causes no register-file access.

The unit accepts one command at a time. After accepting a command it is busy until the command completes. Responses, completions and errors are each single-cycle pulses.

Top module: `vmask_access_unit`

## Requirements
- R1: In ordinary mode (`cmd_carry`=0) with `cmd_vm`=1, a read returns ones in bits 0 to `cmd_num`-1, whatever the register holds.
- R2: With `cmd_vm`=0, in either mode, read bit i for i < `cmd_num` equals bit i of the register addressed by `cmd_vreg`.
- R3: In carry mode (`cmd_carry`=1) with `cmd_vm`=1, a read returns all zeros.
- R4: A write (`cmd_write`=1) sets bits 0 to `cmd_num`-1 of the destination register to the same bits of `cmd_wbits`.
- R5: A write leaves bits `cmd_num` to VLEN-1 of the destination register at their previous values.
- R6: Bits of `rsp_en` at positions `cmd_num` and above are zero.
- R7: A command with `cmd_num` equal to 0 or greater than VLEN raises `err` for one cycle in the cycle after it is sampled. Such a command causes no register-file read or write and produces no `rsp_valid` or `done`.
- R8: Timing and busy behaviour:
  - A legal command sampled at clock edge k gives a one-cycle `rsp_valid` (read) or `done` (write) after edge k+2.
  - `ready` is low from edge k until then.
  - Commands presented while `ready` is low are ignored.
- R9: Register-file sequencing:
  - `rf_re` and `rf_we` are never high together.
  - A write reads the destination in one cycle and writes the same address in the next cycle.
  - Read data returns one cycle after `rf_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; sampled only while `ready` is high |
| cmd_write | input | 1 | 1 = mask write, 0 = mask read |
| cmd_vreg | input | AW | Register number to read or write |
| cmd_vm | input | 1 | 1 = unmasked case, 0 = use register bits |
| cmd_carry | input | 1 | 1 = carry/borrow meaning, 0 = ordinary mask meaning |
| cmd_num | input | NUM_W | Active element count |
| cmd_wbits | input | VLEN | Result mask bits for a write |
| ready | output | 1 | Unit idle and able to take a command |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_en` holds a read result |
| rsp_en | output | VLEN | Element enable / carry-in vector |
| done | output | 1 | One-cycle pulse: write completed |
| err | output | 1 | One-cycle pulse: illegal element count rejected |
| rf_re | output | 1 | Register-file read strobe |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | AW | Register-file address |
| rf_wdata | output | VLEN | Register-file write data |
| rf_rdata | input | VLEN | Register-file read data, valid one cycle after `rf_re` |

## Verification
The in-design properties check the following on every cycle:
- the single-port discipline and the read-then-write order at a fixed address;
- that every write keeps the bits above the element count and carries the new bits below it;
- that read results are zero above the count;
- the all-ones and all-zero unmasked results;
- the rejection of bad counts.

Some behaviours can only be shown by the bench's scenarios, because they depend on what the register file holds before and after:
- that masked reads follow the addressed register's bits in both modes;
- that a rejected write leaves its register untouched;
- that commands offered while busy vanish;
- the exact arrival cycle of each pulse.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_APPLY = 2'd2
    } vm_state_e;
endpackage

// File: rtl/vmask_range_chk.sv
module vmask_range_chk #(
    parameter int VLEN  = 128,
    parameter int NUM_W = $clog2(VLEN + 1)
) (
    input  logic [NUM_W-1:0] num,
    output logic             ok
);
    localparam logic [NUM_W-1:0] LIMIT = NUM_W'(VLEN);

    always_comb begin
        ok = (num != '0) && (num <= LIMIT);
    end
endmodule

// File: rtl/vmask_expand.sv
module vmask_expand #(
    parameter int VLEN  = 128,
    parameter int NUM_W = $clog2(VLEN + 1)
) (
    input  logic [VLEN-1:0]  reg_bits,
    input  logic             vm,
    input  logic             carry,
    input  logic [NUM_W-1:0] num,
    output logic [VLEN-1:0]  en
);
    // Unmasked case: all ones in ordinary mode, all zeros in carry mode.
    logic unmasked_val;
    assign unmasked_val = ~carry;

    for (genvar g = 0; g < VLEN; g++) begin : g_lane
        localparam logic [NUM_W-1:0] IDX = NUM_W'(g);
        logic live;
        assign live  = (IDX < num);
        assign en[g] = live & (vm ? unmasked_val : reg_bits[g]);
    end
endmodule

// File: rtl/vmask_merge.sv
module vmask_merge #(
    parameter int VLEN  = 128,
    parameter int NUM_W = $clog2(VLEN + 1)
) (
    input  logic [VLEN-1:0]  old_bits,
    input  logic [VLEN-1:0]  new_bits,
    input  logic [NUM_W-1:0] num,
    output logic [VLEN-1:0]  merged
);
    for (genvar g = 0; g < VLEN; g++) begin : g_bit
        localparam logic [NUM_W-1:0] IDX = NUM_W'(g);
        assign merged[g] = (IDX < num) ? new_bits[g] : old_bits[g];
    end
endmodule

// File: rtl/vmask_access_unit.sv
module vmask_access_unit
    import vmask_pkg::*;
#(
    parameter int VLEN  = 128,
    parameter int NREG  = 32,
    parameter int AW    = $clog2(NREG),
    parameter int NUM_W = $clog2(VLEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [AW-1:0]    cmd_vreg,
    input  logic             cmd_vm,
    input  logic             cmd_carry,
    input  logic [NUM_W-1:0] cmd_num,
    input  logic [VLEN-1:0]  cmd_wbits,
    output logic             ready,
    output logic             rsp_valid,
    output logic [VLEN-1:0]  rsp_en,
    output logic             done,
    output logic             err,
    output logic             rf_re,
    output logic             rf_we,
    output logic [AW-1:0]    rf_addr,
    output logic [VLEN-1:0]  rf_wdata,
    input  logic [VLEN-1:0]  rf_rdata
);
    typedef struct packed {
        vm_state_e        st;
        logic             write;
        logic [AW-1:0]    vreg;
        logic             vm;
        logic             carry;
        logic [NUM_W-1:0] num;
        logic [VLEN-1:0]  wbits;
        logic             rsp_valid;
        logic [VLEN-1:0]  rsp_en;
        logic             done;
        logic             err;
    } vm_regs_t;

    vm_regs_t r_d, r_q;

    logic            num_ok;
    logic [VLEN-1:0] en_vec;
    logic [VLEN-1:0] merged;

    vmask_range_chk #(.VLEN(VLEN), .NUM_W(NUM_W)) i_range (
        .num (cmd_num),
        .ok  (num_ok)
    );

    vmask_expand #(.VLEN(VLEN), .NUM_W(NUM_W)) i_expand (
        .reg_bits (rf_rdata),
        .vm       (r_q.vm),
        .carry    (r_q.carry),
        .num      (r_q.num),
        .en       (en_vec)
    );

    vmask_merge #(.VLEN(VLEN), .NUM_W(NUM_W)) i_merge (
        .old_bits (rf_rdata),
        .new_bits (r_q.wbits),
        .num      (r_q.num),
        .merged   (merged)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.done      = 1'b0;
        r_d.err       = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (num_ok) begin
                        r_d.st    = ST_FETCH;
                        r_d.write = cmd_write;
                        r_d.vreg  = cmd_vreg;
                        r_d.vm    = cmd_vm;
                        r_d.carry = cmd_carry;
                        r_d.num   = cmd_num;
                        r_d.wbits = cmd_wbits;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                r_d.st = ST_APPLY;
            end
            ST_APPLY: begin
                r_d.st = ST_IDLE;
                if (r_q.write) begin
                    r_d.done = 1'b1;
                end else begin
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_en    = en_vec;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready     = (r_q.st == ST_IDLE);
    assign rf_re     = (r_q.st == ST_FETCH);
    assign rf_we     = (r_q.st == ST_APPLY) && r_q.write;
    assign rf_addr   = r_q.vreg;
    assign rf_wdata  = merged;
    assign rsp_valid = r_q.rsp_valid;
    assign rsp_en    = r_q.rsp_en;
    assign done      = r_q.done;
    assign err       = r_q.err;

    // R9: one port, never read and write together
    p_single_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_re && rf_we));

    // R9: a write fetch is followed by the write at the same address
    p_rmw_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_re && r_q.write) |=> (rf_we && $stable(rf_addr)));

    // R5: bits at and above the count are copied from the old contents
    p_tail_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (((rf_wdata ^ rf_rdata) >> r_q.num) == '0));

    // R4: bits below the count come from the result vector
    p_head_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (((rf_wdata ^ r_q.wbits) << (VLEN - int'(r_q.num))) == '0));

    // R6: read result is zero above the count
    p_rsp_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_en >> r_q.num) == '0));

    // R3: carry mode unmasked gives zero carry-in
    p_carry_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && r_q.carry && r_q.vm) |-> (rsp_en == '0));

    // R1: ordinary mode unmasked enables every active element
    p_unmasked_all_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !r_q.carry && r_q.vm) |-> (rsp_en == ~({VLEN{1'b1}} << r_q.num)));

    // R7: a bad count is rejected with no register access
    p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ready && ((cmd_num == '0) || (int'(cmd_num) > VLEN)))
            |=> (err && !rf_re && ready));

    // R8: write completion follows the write strobe and frees the unit
    p_done_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> (done && ready));
endmodule

// File: tb/test_vmask_access_unit.sv
`timescale 1ns/1ps
module test_vmask_access_unit;
    localparam int VLEN  = 128;
    localparam int NREG  = 32;
    localparam int AW    = 5;
    localparam int NUM_W = 8;

    localparam int K_RSP  = 1;
    localparam int K_DONE = 2;
    localparam int K_ERR  = 3;

    typedef struct {
        int              kind;
        logic [VLEN-1:0] val;
        int              when;
        string           req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_write = 1'b0;
    logic [AW-1:0]    cmd_vreg = '0;
    logic             cmd_vm = 1'b0;
    logic             cmd_carry = 1'b0;
    logic [NUM_W-1:0] cmd_num = '0;
    logic [VLEN-1:0]  cmd_wbits = '0;
    logic             ready, rsp_valid, done, err, rf_re, rf_we;
    logic [VLEN-1:0]  rsp_en, rf_wdata;
    logic [VLEN-1:0]  rf_rdata = '0;
    logic [AW-1:0]    rf_addr;

    logic [VLEN-1:0] rf_mem [NREG];
    logic [VLEN-1:0] shadow [NREG];
    exp_t            expq[$];
    int              cyc = 0;
    int              tests = 0;
    int              fails = 0;
    bit              finished = 0;

    always #4 clk = ~clk;

    vmask_access_unit #(.VLEN(VLEN), .NREG(NREG)) i_vmask_access_unit (
        .clk, .rst_n, .cmd_valid, .cmd_write, .cmd_vreg, .cmd_vm, .cmd_carry,
        .cmd_num, .cmd_wbits, .ready, .rsp_valid, .rsp_en, .done, .err,
        .rf_re, .rf_we, .rf_addr, .rf_wdata, .rf_rdata
    );

    function automatic logic [VLEN-1:0] pat(int r);
        logic [VLEN-1:0] v;
        for (int w = 0; w < VLEN / 32; w++)
            v[w*32 +: 32] = 32'h9E3779B9 * (r * 4 + w + 1);
        return v;
    endfunction

    function automatic logic [VLEN-1:0] low_mask(int n);
        logic [VLEN-1:0] m = '0;
        for (int i = 0; i < VLEN; i++) m[i] = (i < n);
        return m;
    endfunction

    // Bench-side register file: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) rf_mem[r] <= pat(r);
        end else begin
            if (rf_re) rf_rdata <= rf_mem[rf_addr];
            if (rf_we) rf_mem[rf_addr] <= rf_wdata;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic note(bit ok, string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic issue(bit wr, int vreg, bit vm, bit carry, int num,
                         logic [VLEN-1:0] wbits, string req);
        exp_t e;
        logic [VLEN-1:0] m;
        @(negedge clk);
        while (!ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_vreg = AW'(vreg); cmd_vm = vm;
        cmd_carry = carry; cmd_num = NUM_W'(num); cmd_wbits = wbits;
        e.req = req;
        e.val = '0;
        if (num == 0 || num > VLEN) begin
            e.kind = K_ERR; e.when = cyc + 1;
        end else begin
            m = low_mask(num);
            e.when = cyc + 3;
            if (wr) begin
                e.kind = K_DONE;
                shadow[vreg] = (shadow[vreg] & ~m) | (wbits & m);
            end else begin
                e.kind = K_RSP;
                if (vm) e.val = carry ? '0 : m;
                else    e.val = shadow[vreg] & m;
            end
        end
        expq.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rsp_valid) pop_cmp(K_RSP, rsp_en);
            if (done)      pop_cmp(K_DONE, '0);
            if (err)       pop_cmp(K_ERR, '0);
        end
    end

    task automatic pop_cmp(int kind, logic [VLEN-1:0] val);
        exp_t e;
        if (expq.size() == 0) begin
            note(0, "R8 unexpected event", VLEN'(kind), '0);
            return;
        end
        e = expq.pop_front();
        note(e.kind == kind, {e.req, " kind"}, VLEN'(kind), VLEN'(e.kind));
        note(e.when == cyc, {e.req, " R8 timing"}, VLEN'(cyc), VLEN'(e.when));
        if (kind == K_RSP) note(val == e.val, e.req, val, e.val);
    endtask

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        for (int r = 0; r < NREG; r++) shadow[r] = pat(r);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        note(ready && !rsp_valid && !done && !err && !rf_re && !rf_we,
             "reset state", {ready, rsp_valid, done, err, rf_re, rf_we}, VLEN'(6'b100000));

        issue(0, 2, 1, 0, 128, '0, "R1 unmasked full");
        issue(0, 2, 1, 0, 5, '0, "R1 R6 unmasked short");
        issue(0, 3, 0, 0, 128, '0, "R2 masked full");
        issue(0, 7, 0, 0, 37, '0, "R2 R6 masked partial");
        issue(0, 9, 0, 1, 100, '0, "R2 carry masked");
        issue(0, 9, 1, 1, 128, '0, "R3 carry unmasked");
        issue(0, 9, 1, 1, 1, '0, "R3 carry unmasked one");

        issue(1, 4, 0, 0, 20, {4{32'h0F0F_A5A5}}, "R4 R5 write 20");
        issue(0, 4, 0, 0, 128, '0, "R4 R5 readback r4");
        issue(1, 31, 0, 0, 128, {4{32'h1234_5678}}, "R4 write full");
        issue(0, 31, 0, 0, 128, '0, "R4 readback r31");
        issue(1, 0, 0, 0, 1, '0, "R4 R5 write one");
        issue(0, 0, 0, 0, 128, '0, "R5 readback r0");
        issue(1, 6, 0, 0, 127, '1, "R4 R5 write 127");
        issue(0, 6, 0, 0, 128, '0, "R5 readback r6");

        issue(1, 5, 0, 0, 0, '1, "R7 zero count write");
        issue(0, 5, 0, 0, 128, '0, "R7 r5 untouched");
        issue(0, 5, 0, 0, 129, '0, "R7 count over width");
        issue(1, 5, 0, 0, 255, '1, "R7 max count write");
        issue(0, 5, 0, 0, 128, '0, "R7 r5 still untouched");

        // R8: command offered while busy must vanish
        issue(0, 8, 0, 0, 64, '0, "R8 busy base read");
        note(!ready, "R8 ready low while busy", VLEN'(ready), '0);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_num = '0; cmd_vreg = 5'd8;
        @(negedge clk);
        cmd_valid = 1'b0;
        issue(0, 8, 0, 0, 128, '0, "R8 r8 after ignored cmd");

        repeat (6) @(negedge clk);
        note(expq.size() == 0, "R8 all responses seen", VLEN'(expq.size()), '0);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
        end
    end
endmodule